// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Interface Model

This block models the digital face of a six-channel sampling converter whose channels are grouped into three pairs. Each pair has its own start input. A rising edge on any start input begins a conversion on that pair and raises a single shared busy flag. While the flag is high, every start input is locked out. After a fixed number of clock cycles the block stores one result for each channel of every pair that was requested. Sample values come from a deterministic internal pattern.

Once busy drops, a host uses an active-low select and an active-low read strobe to collect the results. Each completed read strobe moves to the next stored result. Results come out in rising channel order, and pairs that were not sampled are skipped. In word mode a result fills the 16-bit bus. In byte mode each result is split over two reads, both placed on bus bits 15:8. A byte-order input chooses which half comes out first. Start and read strobes are synchronized to the clock before any edge detection.

Top module: `simsamp_adc_if`

## Requirements
- R1: A rising edge on trigPair[p] while idle sets busy on the third rising clock edge after the pin changes. Busy then stays high for exactly CONV_CYCLES clock cycles.
- R2: Rising edges on any trigPair bit while busy is high are ignored. The pair of such an edge is neither sampled nor read back.
- R3: Start bits that rise in the same cycle are converted together, so any subset of the three pairs can be sampled in one conversion.
- R4: After busy falls, each completed read returns the next stored channel in ascending order (channels 2p+1 and 2p+2 for pair p), covering only the sampled pairs. While busy is high the bus reads zero.
- R5: busOe is high only while both selN and rdN are low. While busOe is low, busOut is zero and the read pointer does not move.
- R6: The sample of channel c (1 to 6) in conversion n (counted from 0 after reset, modulo 16) is {c[3:0], n[3:0], 8'h30+c}, masked to its low RES_BITS bits. In word mode, bus bits above RES_BITS read zero.
- R7: With byteMode high, each result takes two reads, both driven on busOut[15:8], and busOut[7:0] reads zero.
- R8: With byteMode high, hiFirst low returns the low byte first, and hiFirst high returns the high byte first.
- R9: In byte mode, a conversion of all three pairs yields exactly 12 non-empty reads.
- R10: A new conversion discards any results left unread from the previous one.
- R11: Reads after the last result return zero and do not advance.
- R12: After reset, busy is low, busOe is low, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigPair | input | 3 | Conversion start per channel pair, rising edge active |
| selN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe; a read completes when it ends |
| byteMode | input | 1 | 1 = byte-split readout on bits 15:8 |
| hiFirst | input | 1 | Byte mode: 1 = high byte first, 0 = low byte first |
| busy | output | 1 | Conversion in progress |
| busOut | output | 16 | Data bus value |
| busOe | output | 1 | Data bus output enable |

## Verification
A start pulse passes through two synchronizer flops, so busy is sampled low one clock after the pulse and high the clock after that. It is then sampled high CONV_CYCLES-1 cycles later and low on the next cycle. These samples confirm both the rise latency and the exact conversion length. Bus data is combinational from the read pointer, so the bench samples it one cycle into the strobe. After releasing the strobe, the bench waits four cycles, which covers the synchronizer and the pointer update, before starting the next read. All inputs change on falling clock edges, and all outputs are sampled there too.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_CH    = 2 * NUM_PAIRS;
  localparam int CH_W      = $clog2(NUM_CH + 1);

  typedef struct packed {
    logic                 capture;
    logic [NUM_PAIRS-1:0] pairs;
    logic [CH_W-1:0]      rdCh;
    logic                 bytePhase;
  } ctrlStrobes_t;
endpackage

// File: rtl/simsamp_ctrl.sv
module simsamp_ctrl
  import simsamp_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] trigPair,
  input  logic                 selN,
  input  logic                 rdN,
  input  logic                 byteMode,
  output logic                 busy,
  output ctrlStrobes_t         strobes
);
  localparam int CNT_W  = $clog2(CONV_CYCLES) + 1;
  localparam int SYNC_W = NUM_PAIRS + 1;
  localparam logic [CH_W-1:0] EMPTY = CH_W'(NUM_CH);

  logic [SYNC_W-1:0] syncPipe [SYNC_STAGES];
  logic [SYNC_W-1:0] syncPrev;
  logic [SYNC_W-1:0] syncOut;
  logic [NUM_PAIRS-1:0] trigRise;
  logic readEnd;

  // bit NUM_PAIRS carries the combined read-active level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
      syncPrev <= '0;
    end else begin
      syncPipe[0] <= {~selN & ~rdN, trigPair};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      syncPrev <= syncOut;
    end
  end

  assign syncOut  = syncPipe[SYNC_STAGES-1];
  assign trigRise = syncOut[NUM_PAIRS-1:0] & ~syncPrev[NUM_PAIRS-1:0];
  assign readEnd  = syncPrev[NUM_PAIRS] & ~syncOut[NUM_PAIRS];

  function automatic logic [CH_W-1:0] firstFrom(input logic [NUM_PAIRS-1:0] m,
                                                input logic [CH_W-1:0] fromPair);
    logic [CH_W-1:0] r;
    r = EMPTY;
    for (int p = NUM_PAIRS - 1; p >= 0; p--)
      if (CH_W'(p) >= fromPair && m[p]) r = CH_W'(2 * p);
    return r;
  endfunction

  logic                 busyQ;
  logic [CNT_W-1:0]     cnt;
  logic [NUM_PAIRS-1:0] pendPairs;
  logic [CH_W-1:0]      rdCh;
  logic                 phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ     <= 1'b0;
      cnt       <= '0;
      pendPairs <= '0;
      rdCh      <= EMPTY;
      phase     <= 1'b0;
    end else if (!busyQ && |trigRise) begin
      busyQ     <= 1'b1;
      cnt       <= CNT_W'(CONV_CYCLES - 1);
      pendPairs <= trigRise;
      rdCh      <= EMPTY;
      phase     <= 1'b0;
    end else if (busyQ) begin
      if (cnt == '0) begin
        busyQ <= 1'b0;
        rdCh  <= firstFrom(pendPairs, '0);
        phase <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (readEnd && rdCh != EMPTY) begin
      if (byteMode && !phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (!rdCh[0]) rdCh <= rdCh + 1'b1;
        else rdCh <= firstFrom(pendPairs, {1'b0, rdCh[CH_W-1:1]} + 1'b1);
      end
    end
  end

  assign busy              = busyQ;
  assign strobes.capture   = busyQ && (cnt == '0);
  assign strobes.pairs     = pendPairs;
  assign strobes.rdCh      = rdCh;
  assign strobes.bytePhase = phase;
endmodule

// File: rtl/simsamp_datapath.sv
module simsamp_datapath
  import simsamp_pkg::*;
#(
  parameter int RES_BITS = 14,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              selN,
  input  logic              rdN,
  input  logic              byteMode,
  input  logic              hiFirst,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] RES_MASK = {DATA_W{1'b1}} >> (DATA_W - RES_BITS);

  logic [3:0]        seqCnt;
  logic [DATA_W-1:0] res [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seqCnt <= '0;
    else if (strobes.capture) seqCnt <= seqCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    for (genvar l = 0; l < 2; l++) begin : g_lane
      localparam logic [3:0] TAG = 4'(2 * g + l + 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res[2*g+l] <= '0;
        else if (strobes.capture && strobes.pairs[g])
          res[2*g+l] <= DATA_W'({TAG, seqCnt, 8'(8'h30 + 8'(TAG))}) & RES_MASK;
      end
    end
  end

  logic [DATA_W-1:0] word;
  logic [HALF-1:0]   byteVal;
  logic [DATA_W-1:0] shown;

  always_comb begin
    word    = (strobes.rdCh == CH_W'(NUM_CH)) ? '0 : res[strobes.rdCh];
    byteVal = (hiFirst ^ strobes.bytePhase) ? word[DATA_W-1:HALF] : word[HALF-1:0];
    shown   = byteMode ? {byteVal, {HALF{1'b0}}} : word;
  end

  assign busOe  = ~selN & ~rdN;
  assign busOut = busOe ? shown : '0;
endmodule

// File: rtl/simsamp_adc_if.sv
module simsamp_adc_if
  import simsamp_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int RES_BITS    = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  trigPair,
  input  logic        selN,
  input  logic        rdN,
  input  logic        byteMode,
  input  logic        hiFirst,
  output logic        busy,
  output logic [15:0] busOut,
  output logic        busOe
);
  ctrlStrobes_t strobes;

  simsamp_ctrl #(.CONV_CYCLES(CONV_CYCLES), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigPair(trigPair), .selN(selN), .rdN(rdN),
    .byteMode(byteMode), .busy(busy), .strobes(strobes)
  );

  simsamp_datapath #(.RES_BITS(RES_BITS), .DATA_W(16)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .selN(selN), .rdN(rdN),
    .byteMode(byteMode), .hiFirst(hiFirst), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/simsamp_adc_if_chk.sv
module simsamp_adc_if_chk #(
  parameter int CONV_CYCLES = 20,
  parameter int RES_BITS    = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        busOe,
  input logic [15:0] busOut,
  input logic        byteMode
);
  int busyLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  assert_busy_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busyLen == CONV_CYCLES);

  assert_quiet_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busOut == 16'h0);

  assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busOe |-> busOut == 16'h0);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busOe && !byteMode) |-> (busOut >> RES_BITS) == 16'h0);

  assert_low_byte_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byteMode |-> busOut[7:0] == 8'h0);
endmodule

bind simsamp_adc_if simsamp_adc_if_chk #(.CONV_CYCLES(CONV_CYCLES), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .busOe(busOe), .busOut(busOut), .byteMode(byteMode)
);

// File: tb/simsamp_adc_if_bench.sv
`timescale 1ns/1ps
module simsamp_adc_if_bench;
  localparam int CONV = 20;
  localparam int RES  = 14;
  localparam logic [15:0] MASK = 16'h3FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] trigPair = '0;
  logic selN = 1'b1, rdN = 1'b1, byteMode = 1'b0, hiFirst = 1'b0;
  logic busy, busOe;
  logic [15:0] busOut;

  int nChecks = 0, nFails = 0, convN = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  simsamp_adc_if #(.CONV_CYCLES(CONV), .RES_BITS(RES)) u_simsamp_adc_if (
    .clk(clk), .rst_n(rst_n), .trigPair(trigPair), .selN(selN), .rdN(rdN),
    .byteMode(byteMode), .hiFirst(hiFirst), .busy(busy), .busOut(busOut), .busOe(busOe)
  );

  // {pair mask, byteMode, hiFirst}
  localparam logic [4:0] VEC [6] = '{
    {3'b011, 1'b0, 1'b0}, {3'b101, 1'b0, 1'b0}, {3'b111, 1'b0, 1'b0},
    {3'b010, 1'b1, 1'b0}, {3'b100, 1'b1, 1'b1}, {3'b111, 1'b1, 1'b1}
  };

  function automatic logic [15:0] sampleVal(input int c, input int n);
    return {4'(c), 4'(n), 8'(8'h30 + c)} & MASK;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk) trigPair = m;
    @(negedge clk) trigPair = '0;
  endtask

  task automatic checkRise();
    @(negedge clk) chk("R1 busy before sync", busy, 1'b0);
    @(negedge clk) chk("R1 busy rise", busy, 1'b1);
  endtask

  task automatic waitDone();
    repeat (CONV - 1) @(negedge clk);
    chk("R1 busy held", busy, 1'b1);
    @(negedge clk) chk("R1 busy fall", busy, 1'b0);
  endtask

  task automatic doRead(input logic [15:0] exp, input string tag);
    @(negedge clk) begin selN = 0; rdN = 0; end
    @(negedge clk) begin
      chk({tag, " oe"}, busOe, 1'b1);
      chk(tag, busOut, exp);
      selN = 1; rdN = 1;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 1'b0);
    chk("R12 oe", busOe, 1'b0);
    chk("R12 bus", busOut, 16'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    doRead(16'h0, "R12 read");

    // table walk: R3 R4 R6 R7 R8 R9 R11
    for (int i = 0; i < 6; i++) begin
      logic [2:0] m;
      int reads;
      m = VEC[i][4:2];
      @(negedge clk) begin byteMode = VEC[i][1]; hiFirst = VEC[i][0]; end
      pulse(m);
      checkRise();
      waitDone();
      reads = 0;
      for (int p = 0; p < 3; p++) begin
        if (m[p]) begin
          for (int l = 0; l < 2; l++) begin
            logic [15:0] v;
            v = sampleVal(2 * p + l + 1, convN);
            if (!VEC[i][1]) begin
              doRead(v, "R4 R6 word order");
              reads++;
            end else begin
              doRead({VEC[i][0] ? v[15:8] : v[7:0], 8'h00}, "R8 first byte");
              doRead({VEC[i][0] ? v[7:0] : v[15:8], 8'h00}, "R7 second byte");
              reads += 2;
            end
          end
        end
      end
      doRead(16'h0, "R11 past end");
      if (m == 3'b111 && VEC[i][1]) chk("R9 byte read count", reads, 12);
      convN++;
    end
    doRead(16'h0, "R11 stays empty");
    @(negedge clk) byteMode = 0;

    // R2 lockout, R4 bus quiet while busy
    pulse(3'b001);
    checkRise();
    pulse(3'b100);
    doRead(16'h0, "R4 busy read");
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    chk("R2 busy done", busy, 1'b0);
    doRead(sampleVal(1, convN), "R2 ch1");
    doRead(sampleVal(2, convN), "R2 ch2");
    doRead(16'h0, "R2 locked pair absent");
    convN++;

    // R10 discard, R5 enable
    pulse(3'b011);
    checkRise();
    waitDone();
    doRead(sampleVal(1, convN), "R10 first");
    convN++;
    @(negedge clk) begin selN = 1; rdN = 0; end
    @(negedge clk) begin
      chk("R5 oe sel high", busOe, 1'b0);
      chk("R5 bus sel high", busOut, 16'h0);
      rdN = 1;
    end
    repeat (4) @(negedge clk);
    pulse(3'b100);
    checkRise();
    waitDone();
    doRead(sampleVal(5, convN), "R10 ch5");
    doRead(sampleVal(6, convN), "R10 ch6");
    doRead(16'h0, "R10 old gone");
    convN++;

    summary();
  end
endmodule